// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is a general-purpose I/O port of `N` pins that sits on a simple processor bus. Three register addresses hold the port state: a pin-level address that reads the synchronized pad values, a direction address, and a drive/pull address. Each bit of the drive/pull register has two roles. When its pin is an output, the bit is the value driven. When its pin is an input, the bit turns on that pin's pull-up. A global pull-up disable input overrides the pull-up for every pin at once.

Pad inputs pass through a two-stage synchronizer clocked by the I/O clock. A sleep input forces that path to 0 ahead of the synchronizer, so floating pads cannot disturb internal logic while the core sleeps. Writing ones to the pin-level address flips the matching drive/pull bits. This allows single-write toggling of outputs. Reset is asynchronous and releases every pad to high impedance without waiting for a clock edge.

The bus is a plain strobe interface: writes complete in the cycle in which `bus_wr` is high, and read data is combinational. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `gpio_port`

## Requirements
- R1: While `rst_n` is low, the direction and drive/pull registers are cleared at once, with no clock edge needed, so `pad_oe`, `pad_out` and `pad_pue` are all zero.
- R2: A write (`bus_wr`=1) to address 1 loads `bus_wdata` into the direction register on the next clock edge. Bit n = 1 makes pin n an output (`pad_oe[n]`=1). Bit n = 0 makes it an input.
- R3: A write to address 2 loads `bus_wdata` into the drive/pull register on the next clock edge.
- R4: `pad_out[n]` equals drive/pull bit n when pin n is an output, and is 0 when pin n is an input.
- R5: `pad_pue[n]` is 1 only when pin n is an input, drive/pull bit n is 1, and `pud_all` is 0. It is never 1 together with `pad_oe[n]`.
- R6: While `pud_all` is 1, every bit of `pad_pue` is 0, whatever the register contents are.
- R7: A read (`bus_rd`=1) of address 0 returns the pad value as it stood two rising clock edges earlier. After only one edge, the read still shows the previous value.
- R8: A write to address 0 inverts each drive/pull bit whose `bus_wdata` bit is 1 and leaves bits with a 0 unchanged. The synchronized pin values cannot be written.
- R9: While `sleep` is 1, the value entering the synchronizer is 0 for all pins, so address 0 reads 0 two edges later. `pad_oe` and `pad_out` do not change because of sleep.
- R10: Reads of addresses 1 and 2 return the register contents combinationally. Address 3 reads 0 and a write to it changes nothing. `bus_rdata` is 0 whenever `bus_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 pin level, 1 direction, 2 drive/pull |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | N | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | N | Combinational read data |
| pud_all | input | 1 | Global pull-up disable |
| sleep | input | 1 | Gates the pad input path to 0 |
| pad_in | input | N | Pad input levels |
| pad_oe | output | N | Per-pin output enable |
| pad_out | output | N | Per-pin driven value |
| pad_pue | output | N | Per-pin pull-up enable |

## Verification
The assertions check the following on every cycle: the pad controls are exclusive (no pull-up on a driven pin, and no pull-up at all while the disable is active), the registers are empty during reset, writes and toggles land in the registers one edge later, and the synchronizer input stays at zero during sleep. Some behaviours can only be shown by the bench's scenarios. These are the exact two-edge latency from pad to read data, the release of the pads by reset between clock edges, the dead address, and the interaction of pull-up with direction across a sequence of writes.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    SEL_LEVEL = 2'd0,
    SEL_DIR   = 2'd1,
    SEL_DRIVE = 2'd2,
    SEL_NONE  = 2'd3
  } gpio_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  gpio_sel_e    sel,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] dir_q,
  output logic [N-1:0] drv_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      drv_q <= '0;
    end else if (wr) begin
      case (sel)
        SEL_DIR:   dir_q <= wdata;
        SEL_DRIVE: drv_q <= wdata;
        SEL_LEVEL: drv_q <= drv_q ^ wdata;
        default:   ;
      endcase
    end
  end

  // R1: registers empty while reset is held
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (dir_q == '0 && drv_q == '0));

  // R2: direction write lands one edge later
  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_DIR) |=> dir_q == $past(wdata));

  // R8: toggle write flips exactly the selected bits
  assert_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_LEVEL) |=> drv_q == ($past(drv_q) ^ $past(wdata)));

  // R10: dead address leaves both registers untouched
  assert_dead_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_NONE) |=> ($stable(dir_q) && $stable(drv_q)));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sleep,
  input  logic [N-1:0] pad_in,
  output logic [N-1:0] level_q
);
  logic [N-1:0] gated;
  logic [N-1:0] stage1_q;

  assign gated = sleep ? '0 : pad_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      level_q  <= '0;
    end else begin
      stage1_q <= gated;
      level_q  <= stage1_q;
    end
  end

  // R9: nothing but zero enters the synchronizer during sleep
  assert_sleep_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> stage1_q == '0);

  // R7: second stage follows the first by one edge
  assert_sync_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> level_q == $past(stage1_q));
endmodule

// File: rtl/gpio_padctl.sv
module gpio_padctl #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pud_all,
  input  logic [N-1:0] dir_q,
  input  logic [N-1:0] drv_q,
  output logic [N-1:0] pad_oe,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_pue
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    assign pad_oe[i]  = dir_q[i];
    assign pad_out[i] = dir_q[i] & drv_q[i];
    assign pad_pue[i] = ~dir_q[i] & drv_q[i] & ~pud_all;
  end

  // R5: pull-up never on a driven pin
  assert_pue_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pue & pad_oe) == '0);

  // R6: global disable kills every pull-up
  assert_pud_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pud_all |-> pad_pue == '0);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   bus_addr,
  input  logic         bus_wr,
  input  logic [N-1:0] bus_wdata,
  input  logic         bus_rd,
  output logic [N-1:0] bus_rdata,
  input  logic         pud_all,
  input  logic         sleep,
  input  logic [N-1:0] pad_in,
  output logic [N-1:0] pad_oe,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_pue
);
  gpio_sel_e    sel;
  logic [N-1:0] dir_q;
  logic [N-1:0] drv_q;
  logic [N-1:0] level_q;

  assign sel = gpio_sel_e'(bus_addr);

  gpio_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel(sel),
    .wdata(bus_wdata), .dir_q(dir_q), .drv_q(drv_q)
  );

  gpio_sync #(.N(N)) u_sync (
    .clk(clk), .rst_n(rst_n), .sleep(sleep),
    .pad_in(pad_in), .level_q(level_q)
  );

  gpio_padctl #(.N(N)) u_pad (
    .clk(clk), .rst_n(rst_n), .pud_all(pud_all),
    .dir_q(dir_q), .drv_q(drv_q),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pue(pad_pue)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (sel)
        SEL_LEVEL: bus_rdata = level_q;
        SEL_DIR:   bus_rdata = dir_q;
        SEL_DRIVE: bus_rdata = drv_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R10: idle read bus is zero
  assert_idle_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [N-1:0] bus_wdata = '0;
  logic         bus_rd = 1'b0;
  logic [N-1:0] bus_rdata;
  logic         pud_all = 1'b0;
  logic         sleep = 1'b0;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_oe, pad_out, pad_pue;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  gpio_port #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pud_all(pud_all), .sleep(sleep), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pue(pad_pue)
  );

  // {addr, wdata, pud, exp_oe, exp_out, exp_pue}
  localparam logic [34:0] VEC [8] = '{
    {2'd1, 8'h0F, 1'b0, 8'h0F, 8'h00, 8'h00},  // R2
    {2'd2, 8'h3C, 1'b0, 8'h0F, 8'h0C, 8'h30},  // R3 R4 R5
    {2'd0, 8'h11, 1'b0, 8'h0F, 8'h0D, 8'h20},  // R8 toggle
    {2'd0, 8'h00, 1'b0, 8'h0F, 8'h0D, 8'h20},  // R8 zero write
    {2'd1, 8'h0F, 1'b1, 8'h0F, 8'h0D, 8'h00},  // R6
    {2'd1, 8'h00, 1'b0, 8'h00, 8'h00, 8'h2D},  // R4 R5
    {2'd3, 8'hFF, 1'b0, 8'h00, 8'h00, 8'h2D},  // R10 dead write
    {2'd2, 8'hFF, 1'b0, 8'h00, 8'h00, 8'hFF}   // R3 R5
  };

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [N-1:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] rd;
    #1;
    check("R1 reset oe", pad_oe, '0);
    check("R1 reset pue", pad_pue, '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      pud_all = VEC[i][24];
      bus_write(VEC[i][34:33], VEC[i][32:25]);
      check($sformatf("R2-vec%0d oe", i), pad_oe, VEC[i][23:16]);
      check($sformatf("R4 vec%0d out", i), pad_out, VEC[i][15:8]);
      check($sformatf("R5 vec%0d pue", i), pad_pue, VEC[i][7:0]);
    end

    // R10 readbacks and idle read
    bus_write(2'd1, 8'hA3);
    bus_write(2'd2, 8'h5A);
    bus_read(2'd1, rd); check("R10 read dir", rd, 8'hA3);
    bus_read(2'd2, rd); check("R10 read drive", rd, 8'h5A);
    bus_read(2'd3, rd); check("R10 read dead", rd, 8'h00);
    #1 check("R10 idle rdata", bus_rdata, 8'h00);

    // R7 two-edge latency
    @(negedge clk); pad_in = 8'hA5;
    @(negedge clk); bus_read(2'd0, rd); check("R7 one edge", rd, 8'h00);
    @(negedge clk); bus_read(2'd0, rd); check("R7 two edges", rd, 8'hA5);

    // R9 sleep gating
    @(negedge clk); sleep = 1'b1; pad_in = 8'hFF;
    repeat (2) @(negedge clk);
    bus_read(2'd0, rd); check("R9 sleep read", rd, 8'h00);
    check("R9 oe kept", pad_oe, 8'hA3);
    check("R9 out kept", pad_out, 8'h02);
    sleep = 1'b0;
    repeat (2) @(negedge clk);
    bus_read(2'd0, rd); check("R9 wake read", rd, 8'hFF);

    // R1 asynchronous reset mid-cycle
    @(posedge clk); #1 rst_n = 1'b0;
    #1;
    check("R1 async oe", pad_oe, '0);
    check("R1 async out", pad_out, '0);
    check("R1 async pue", pad_pue, '0);
    @(negedge clk); rst_n = 1'b1;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule